// File: doc/BRIEF.md
# Indexed Character-Pair Streamer

This block plays back one record of paired ASCII characters from read-only tables that are built into the design. It emits one pair per pacing tick. A 6-bit record number addresses a pointer table. Each entry of that table packs a start address and a length. Together they locate the record inside a character table of 16-bit words. Each word holds two characters. The upper byte goes to the function bus and the lower byte goes to the transformed bus. Where the two sides of a record differ in length, the shorter side is already filled out with space characters (0x20) in the stored words.

After the active-low reset is released, the block waits for the enable input. The record number must be stable before enable rises. The first clock edge with enable high loads the pointer entry. Each later tick then emits the next word, in ascending address order. Dropping enable freezes the stream, including the pacing divider. A rate input picks between a tick on every enabled clock and a tick once every `DIV_TICKS` enabled clocks. The default is 50,000,000, a human-readable pace on a fast clock.

Once the record is exhausted, both buses return to spaces and stay there until the next reset. The table contents are small computed test patterns that stand in for generated data.

Top module: `pair_rom_streamer`

## Requirements
- R1: While reset is low and after its release, both output buses read 0x20 until a pair is emitted.
- R2: The pointer entry for record r is 20 bits {start[19:10], length[9:0]}, read at 8-bit pointer address {2'b00, r}. The length is (5r+3) mod 9, and the start is the sum of the lengths of records 0 to r-1.
- R3: The character word at address a carries the function byte in bits [15:8] and the transformed byte in bits [7:0]. The function byte is 0x20 when a mod 4 = 3, and 0x41 + (a mod 26) otherwise. The transformed byte is 0x20 when a mod 6 = 5, and 0x61 + (a mod 26) otherwise.
- R4: In the waiting state, the first clock edge with enable high and a valid record loads the pointer entry. Each following tick shows the next word of the record on the buses, in ascending address order.
- R5: The tick after the last word drives 0x20 on both buses. The block then ignores enable and keeps spaces until reset.
- R6: While enable is low, no tick occurs, both buses hold their values and the divider does not advance.
- R7: With the rate input high, every clock edge with enable high is a tick.
- R8: With the rate input low, a tick occurs on every DIV_TICKS-th enabled clock edge.
- R9: A record number above 43 emits nothing. Both buses stay at 0x20 and the block goes idle.
- R10: A zero-length record (record 3) emits only the closing space pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_idx | input | 6 | Record number, valid 0 to 43 |
| run_en | input | 1 | Enables start and continued streaming |
| full_rate | input | 1 | 1: tick every clock, 0: tick every DIV_TICKS clocks |
| fn_char | output | 8 | Function-side character |
| xf_char | output | 8 | Transformed-side character |

## Verification
The bench builds the block with DIV_TICKS set to 4. This brings the divided pace within a few cycles of each emission, so a paused divided stream can be followed in full. It keeps NUM_RECS at 44, so the first, the last, a zero-length and an out-of-range record can all be played back. A behavioural model fed from the requirement formulas predicts both buses on every clock.

// File: rtl/pair_rom_streamer.sv
module pair_rom_streamer #(
  parameter int DIV_TICKS = 50_000_000,
  parameter int NUM_RECS  = 44,
  parameter int AW        = 10,
  parameter int PW        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] rec_idx,
  input  logic       run_en,
  input  logic       full_rate,
  output logic [7:0] fn_char,
  output logic [7:0] xf_char
);
  localparam int DCW = (DIV_TICKS > 1) ? $clog2(DIV_TICKS) : 1;
  localparam logic [7:0] SP = 8'h20;

  typedef enum logic [1:0] {S_WAIT = 2'd0, S_RUN = 2'd1, S_DONE = 2'd2} st_t;

  function automatic logic [AW-1:0] rec_len(int r);
    return AW'((5 * r + 3) % 9);
  endfunction

  function automatic logic [2*AW-1:0] ptr_rom(logic [PW-1:0] a);
    int s;
    s = 0;
    for (int i = 0; i < NUM_RECS; i++)
      if (i < int'(a)) s += int'(rec_len(i));
    return {AW'(s), rec_len(int'(a))};
  endfunction

  function automatic logic [15:0] chr_rom(logic [AW-1:0] a);
    int m;
    logic [7:0] f, x;
    m = int'(a) % 26;
    f = (a[1:0] == 2'd3) ? SP : 8'(65 + m);
    x = ((int'(a) % 6) == 5) ? SP : 8'(97 + m);
    return {f, x};
  endfunction

  st_t            st;
  logic [AW-1:0]  cur;
  logic [AW-1:0]  left;
  logic [DCW-1:0] div_cnt;

  wire [PW-1:0]   ptr_addr = {{(PW-6){1'b0}}, rec_idx};
  wire [2*AW-1:0] ptr      = ptr_rom(ptr_addr);
  wire [15:0]     word     = chr_rom(cur);
  wire            tick     = run_en && (full_rate || div_cnt == DCW'(DIV_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_WAIT;
      cur     <= '0;
      left    <= '0;
      div_cnt <= '0;
      fn_char <= SP;
      xf_char <= SP;
    end else begin
      case (st)
        S_WAIT:
          if (run_en) begin
            if (int'(rec_idx) < NUM_RECS) begin
              cur  <= ptr[2*AW-1:AW];
              left <= ptr[AW-1:0];
              st   <= S_RUN;
            end else begin
              st <= S_DONE;
            end
          end
        S_RUN:
          if (tick) begin
            div_cnt <= '0;
            if (left == '0) begin
              fn_char <= SP;
              xf_char <= SP;
              st      <= S_DONE;
            end else begin
              fn_char <= word[15:8];
              xf_char <= word[7:0];
              cur     <= cur + 1'b1;
              left    <= left - 1'b1;
            end
          end else if (run_en) begin
            div_cnt <= div_cnt + 1'b1;
          end
        default: ;
      endcase
    end
  end
endmodule

module pair_rom_streamer_chk #(
  parameter int DIV_TICKS = 50_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] rec_idx,
  input logic       run_en,
  input logic       full_rate,
  input logic [7:0] fn_char,
  input logic [7:0] xf_char,
  input logic [1:0] st
);
  localparam logic [1:0] C_WAIT = 2'd0;
  localparam logic [1:0] C_DONE = 2'd2;

  p_reset_space_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fn_char == 8'h20 && xf_char == 8'h20));

  p_pause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(fn_char) && $stable(xf_char)));

  p_done_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_DONE |-> (fn_char == 8'h20 && xf_char == 8'h20));

  p_bad_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WAIT && run_en && rec_idx > 6'd43) |=> st == C_DONE);

  p_slow_pace_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV_TICKS > 1 && !full_rate && $past(!full_rate) && !$stable(fn_char))
      |=> $stable(fn_char));
endmodule

bind pair_rom_streamer pair_rom_streamer_chk #(.DIV_TICKS(DIV_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_idx(rec_idx), .run_en(run_en),
  .full_rate(full_rate), .fn_char(fn_char), .xf_char(xf_char), .st(st)
);

// File: tb/pair_rom_streamer_bench.sv
module pair_rom_streamer_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] rec_idx = '0;
  logic       run_en = 1'b0;
  logic       full_rate = 1'b1;
  logic [7:0] fn_char, xf_char;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  pair_rom_streamer #(.DIV_TICKS(DIV)) u_pair_rom_streamer (
    .clk(clk), .rst_n(rst_n), .rec_idx(rec_idx), .run_en(run_en),
    .full_rate(full_rate), .fn_char(fn_char), .xf_char(xf_char)
  );

  always #10 clk = ~clk;

  function automatic int m_len(int r);
    return (5 * r + 3) % 9;
  endfunction

  function automatic int m_start(int r);
    int s = 0;
    for (int i = 0; i < r; i++) s += m_len(i);
    return s;
  endfunction

  function automatic logic [15:0] m_word(int a);
    logic [7:0] f, x;
    f = (a % 4 == 3) ? 8'h20 : 8'(65 + a % 26);
    x = (a % 6 == 5) ? 8'h20 : 8'(97 + a % 26);
    return {f, x};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural model: 0 waiting, 1 streaming, 2 finished
  int          m_st = 0;
  int          phase = 0;
  logic [15:0] q[$];
  logic [15:0] m_out = 16'h2020;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; phase = 0; q.delete(); m_out = 16'h2020;
    end else if (m_st == 0) begin
      if (run_en) begin
        if (rec_idx <= 6'd43) begin
          for (int k = 0; k < m_len(int'(rec_idx)); k++)
            q.push_back(m_word(m_start(int'(rec_idx)) + k));
          q.push_back(16'h2020);
          m_st = 1; phase = 0;
        end else m_st = 2;
      end
    end else if (m_st == 1 && run_en) begin
      if (full_rate || phase == DIV - 1) begin
        m_out = q.pop_front();
        phase = 0;
        if (q.size() == 0) m_st = 2;
      end else phase++;
    end
    #5;
    check("R2 R3 R4 R7 R8 per-clock", {fn_char, xf_char}, m_out);
  end

  task automatic play(int idx, bit fr, int pause_at, int total);
    logic [15:0] held;
    @(negedge clk);
    rst_n = 1'b0; rec_idx = 6'(idx); full_rate = fr; run_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {fn_char, xf_char}, 16'h2020);
    run_en = 1'b1;
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      if (c == pause_at) begin
        run_en = 1'b0;
        held = {fn_char, xf_char};
        repeat (7) @(negedge clk);
        check("R6 paused hold", {fn_char, xf_char}, held);
        run_en = 1'b1;
      end
    end
  endtask

  initial begin
    // R4 R7: record 0, full rate, three pairs
    play(0, 1'b1, -1, 8);
    check("R5 spaces after record 0", {fn_char, xf_char}, 16'h2020);
    // R8 R6: record 1, divided rate, paused mid stream
    play(1, 1'b0, 13, 45);
    check("R5 spaces after record 1", {fn_char, xf_char}, 16'h2020);
    // R10: zero-length record
    play(3, 1'b1, -1, 6);
    check("R10 zero-length record", {fn_char, xf_char}, 16'h2020);
    // R9: out-of-range index
    play(50, 1'b1, -1, 10);
    check("R9 invalid index", {fn_char, xf_char}, 16'h2020);
    // last record, full rate, then R5 enable toggling ignored
    play(43, 1'b1, -1, 6);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    run_en = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 stays idle after record 43", {fn_char, xf_char}, 16'h2020);
    // record 17, divided rate, no pause
    play(17, 1'b0, -1, 40);
    check("R5 spaces after record 17", {fn_char, xf_char}, 16'h2020);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule